// File: doc/BRIEF.md
# Accelerator Control Register Interface

This block is the software-facing register file of a streaming video memory engine. A host reaches it over an AXI4-Lite slave port. The block holds the engine's run control, its interrupt controls and its frame configuration: active width, active height, line pitch in bytes, memory pixel format code, two plane base addresses and a field polarity value. It drives a start request to the engine and takes back the engine's `done`, `ready`, `idle` and flush-complete indications. It raises a single level interrupt line.

Several register bits have side effects. The start request clears when the engine accepts it. The done flag clears when software reads the control word. Interrupt status bits flip when software writes a 1 to them. With auto-restart set, start re-arms after every completion, so the engine runs back to back with no further software writes.

The AXI channels follow the usual valid/ready rules. A channel transfers on a cycle where both valid and ready are high. The write address and write data channels are accepted separately and in either order. After accepting one of them, the block withholds ready on that channel until the write has been applied. The B and R channels hold valid and their payload until the host raises ready. While a read response is waiting, no new read address is accepted.

Top module: `accel_ctrl_regs`

## Requirements
- R1: AW and W are accepted independently, in either order. A write is applied on the clock edge after both are held and no B response is pending. Exactly one B response follows, and `bvalid` stays high until `bready`.
- R2: Writing 1 to control bit 0 (offset 0x00, strobe 0 set) raises `core_start` on the next cycle. Writing 0 there does not lower it. `core_start` falls on the cycle after `core_ready` is seen high while it is high. A same-cycle software set wins over that clear.
- R3: Control bit 1 (done) sets whenever `core_done` is high. An accepted read of offset 0x00 clears it. If both happen in the same cycle, the bit stays set and that read returns the old value.
- R4: With control bit 7 (auto-restart) set, `core_done` high makes `core_start` high on the next cycle, whatever the handshake is doing.
- R5: Control bit 2 reads `core_idle`, bit 3 reads `core_ready` and bit 6 reads `flush_done`, all live. Bit 5 is read/write and drives `flush_req`.
- R6: Writes to control bits 1, 2, 3, 4, 6 and 8 and above have no effect. Bits 4 and 8 and above read as 0.
- R7: Offset 0x04 bit 0 is the global interrupt enable. Offset 0x08 bits [1:0] are the per-source enables (bit 0 done, bit 1 ready). All other bits read 0. These registers and the control word are written only when strobe 0 is set.
- R8: Offset 0x0C bit 0 sets on a rising edge of `core_done`, and bit 1 on a rising edge of `core_ready`. Writing 1 to a bit flips it. If an edge and a flip land in the same cycle, the bit ends at 1.
- R9: `irq` = global enable AND ((enable0 AND status0) OR (enable1 AND status1)). It follows register changes with no extra delay.
- R10: Configuration registers at 0x10, 0x18, 0x20, 0x28, 0x30, 0x3C and 0x48 are read/write, honour byte strobes, and drive `cfg_width`, `cfg_height`, `cfg_stride`, `cfg_format`, `cfg_plane0`, `cfg_plane1` and `cfg_field`.
- R11: Writes to unmapped offsets change nothing. Reads of them return 0. Every response is OKAY (`bresp` = `rresp` = 0).
- R12: `arready` is low while `rvalid` is high. `rvalid` and `rdata` hold steady until `rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response, always OKAY |
| core_start | output | 1 | Start request to the engine |
| core_done | input | 1 | Engine completion |
| core_ready | input | 1 | Engine accepts start |
| core_idle | input | 1 | Engine idle |
| flush_req | output | 1 | Request to drain memory traffic |
| flush_done | input | 1 | Drain complete |
| irq | output | 1 | Level interrupt |
| cfg_width | output | DATA_W | Active width |
| cfg_height | output | DATA_W | Active height |
| cfg_stride | output | DATA_W | Line pitch in bytes |
| cfg_format | output | DATA_W | Memory format code |
| cfg_plane0 | output | DATA_W | First plane base address |
| cfg_plane1 | output | DATA_W | Second plane base address |
| cfg_field | output | DATA_W | Field polarity |

## Verification
The two functions that can collide are the setting of the done flag by `core_done` and its clearing by a read of the control word. The bench raises `core_done` on the exact cycle in which the read address handshake completes. It then checks three reads in a row: the colliding read returns done as 0, the next read returns it as 1, and the one after that returns 0 again. The interrupt status flip and a `core_done` rising edge are also made to coincide, by timing the pulse to the commit edge of a write. The bit must end at 1.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_GIE  = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h08;
  localparam logic [7:0] OFS_IST  = 8'h0C;

  localparam int unsigned NUM_CFG = 7;
  localparam int unsigned NUM_SRC = 2;

  // control word bit positions
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_DONE  = 1;
  localparam int unsigned CB_IDLE  = 2;
  localparam int unsigned CB_READY = 3;
  localparam int unsigned CB_FLUSH = 5;
  localparam int unsigned CB_FLDN  = 6;
  localparam int unsigned CB_AUTO  = 7;

  // configuration register offsets, indexed by slot
  function automatic logic [7:0] cfg_ofs(input int unsigned idx);
    case (idx)
      0: cfg_ofs = 8'h10;
      1: cfg_ofs = 8'h18;
      2: cfg_ofs = 8'h20;
      3: cfg_ofs = 8'h28;
      4: cfg_ofs = 8'h30;
      5: cfg_ofs = 8'h3C;
      6: cfg_ofs = 8'h48;
      default: cfg_ofs = 8'hFC;
    endcase
  endfunction
endpackage

// File: rtl/accel_axil_wr_join.sv
module accel_axil_wr_join #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output logic [7:0]        c_ofs,
  output logic [DATA_W-1:0] c_data,
  output logic [STRB_W-1:0] c_strb
);
  logic aw_held, w_held, b_pend;

  assign awready = !aw_held;
  assign wready  = !w_held;
  assign bvalid  = b_pend;
  assign commit  = aw_held && w_held && !b_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      b_pend  <= 1'b0;
      c_ofs   <= '0;
      c_data  <= '0;
      c_strb  <= '0;
    end else begin
      if (awvalid && !aw_held) begin
        aw_held <= 1'b1;
        c_ofs   <= awaddr[7:0] & 8'hFC;
      end
      if (wvalid && !w_held) begin
        w_held <= 1'b1;
        c_data <= wdata;
        c_strb <= wstrb;
      end
      if (commit) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        b_pend  <= 1'b1;
      end else if (b_pend && bready) begin
        b_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/accel_ctrl_word.sv
module accel_ctrl_word
  import accel_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              w_start,
  input  logic              w_flush,
  input  logic              w_auto,
  input  logic              rd_clr,
  input  logic              core_done,
  input  logic              core_ready,
  input  logic              core_idle,
  input  logic              flush_done,
  output logic              start_q,
  output logic              done_q,
  output logic              flush_q,
  output logic              auto_q,
  output logic [DATA_W-1:0] word
);
  logic [7:0] bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      // set sources win over the handshake clear
      if ((we && w_start) || (auto_q && core_done)) start_q <= 1'b1;
      else if (start_q && core_ready)               start_q <= 1'b0;
      // a completion wins over the read-side clear
      if (core_done)   done_q <= 1'b1;
      else if (rd_clr) done_q <= 1'b0;
      if (we) begin
        flush_q <= w_flush;
        auto_q  <= w_auto;
      end
    end
  end

  always_comb begin
    bits           = '0;
    bits[CB_START] = start_q;
    bits[CB_DONE]  = done_q;
    bits[CB_IDLE]  = core_idle;
    bits[CB_READY] = core_ready;
    bits[CB_FLUSH] = flush_q;
    bits[CB_FLDN]  = flush_done;
    bits[CB_AUTO]  = auto_q;
    word           = DATA_W'(bits);
  end
endmodule

// File: rtl/accel_irq_ctrl.sv
module accel_irq_ctrl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie_we,
  input  logic            gie_in,
  input  logic            ien_we,
  input  logic [NSRC-1:0] ien_in,
  input  logic            ist_we,
  input  logic [NSRC-1:0] ist_flip,
  input  logic [NSRC-1:0] events,
  output logic            gie_q,
  output logic [NSRC-1:0] ien_q,
  output logic [NSRC-1:0] ist_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (gie_we) gie_q <= gie_in;
      if (ien_we) ien_q <= ien_in;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic st, ev_d;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= 1'b0;
        ev_d <= 1'b0;
      end else begin
        ev_d <= events[i];
        if (events[i] && !ev_d)         st <= 1'b1;
        else if (ist_we && ist_flip[i]) st <= !st;
      end
    end
    assign ist_q[i] = st;
  end

  assign irq = gie_q && |(ien_q & ist_q);
endmodule

// File: rtl/accel_cfg_bank.sv
module accel_cfg_bank
  import accel_regs_pkg::*;
#(
  parameter int unsigned NUM    = NUM_CFG,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [7:0]                  w_ofs,
  input  logic [DATA_W-1:0]           w_data,
  input  logic [STRB_W-1:0]           w_strb,
  input  logic [7:0]                  r_ofs,
  output logic                        r_hit,
  output logic [DATA_W-1:0]           r_data,
  output logic [NUM-1:0][DATA_W-1:0]  regs
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    localparam logic [7:0] MY_OFS = cfg_ofs(i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we && w_ofs == MY_OFS) begin
        for (int b = 0; b < STRB_W; b++)
          if (w_strb[b]) q[b*8 +: 8] <= w_data[b*8 +: 8];
      end
    end
    assign regs[i] = q;
  end

  always_comb begin
    r_hit  = 1'b0;
    r_data = '0;
    for (int i = 0; i < NUM; i++) begin
      if (r_ofs == cfg_ofs(i)) begin
        r_hit  = 1'b1;
        r_data = regs[i];
      end
    end
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              core_start,
  input  logic              core_done,
  input  logic              core_ready,
  input  logic              core_idle,
  output logic              flush_req,
  input  logic              flush_done,
  output logic              irq,
  output logic [DATA_W-1:0] cfg_width,
  output logic [DATA_W-1:0] cfg_height,
  output logic [DATA_W-1:0] cfg_stride,
  output logic [DATA_W-1:0] cfg_format,
  output logic [DATA_W-1:0] cfg_plane0,
  output logic [DATA_W-1:0] cfg_plane1,
  output logic [DATA_W-1:0] cfg_field
);
  logic              wr_commit;
  logic [7:0]        wr_ofs;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              low_byte_we;

  accel_axil_wr_join #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wjoin (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready),
    .commit(wr_commit), .c_ofs(wr_ofs), .c_data(wr_data), .c_strb(wr_strb)
  );
  assign bresp = 2'b00;
  assign low_byte_we = wr_commit && wr_strb[0];

  // read address side
  logic       rvalid_q;
  logic       ar_hs;
  logic [7:0] ar_ofs;
  assign arready = !rvalid_q;
  assign ar_hs   = arvalid && !rvalid_q;
  assign ar_ofs  = araddr[7:0] & 8'hFC;

  logic              done_bit, auto_bit, start_bit, flush_bit;
  logic [DATA_W-1:0] ctrl_word;

  accel_ctrl_word #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we(low_byte_we && wr_ofs == OFS_CTRL),
    .w_start(wr_data[CB_START]), .w_flush(wr_data[CB_FLUSH]), .w_auto(wr_data[CB_AUTO]),
    .rd_clr(ar_hs && ar_ofs == OFS_CTRL),
    .core_done(core_done), .core_ready(core_ready), .core_idle(core_idle),
    .flush_done(flush_done),
    .start_q(start_bit), .done_q(done_bit), .flush_q(flush_bit), .auto_q(auto_bit),
    .word(ctrl_word)
  );
  assign core_start = start_bit;
  assign flush_req  = flush_bit;

  logic               gie_q;
  logic [NUM_SRC-1:0] ien_q, ist_q;

  accel_irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .gie_we(low_byte_we && wr_ofs == OFS_GIE), .gie_in(wr_data[0]),
    .ien_we(low_byte_we && wr_ofs == OFS_IEN), .ien_in(wr_data[NUM_SRC-1:0]),
    .ist_we(low_byte_we && wr_ofs == OFS_IST), .ist_flip(wr_data[NUM_SRC-1:0]),
    .events({core_ready, core_done}),
    .gie_q(gie_q), .ien_q(ien_q), .ist_q(ist_q), .irq(irq)
  );

  logic                             cfg_hit;
  logic [DATA_W-1:0]                cfg_rd;
  logic [NUM_CFG-1:0][DATA_W-1:0]   cfg_q;

  accel_cfg_bank #(.NUM(NUM_CFG), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .we(wr_commit), .w_ofs(wr_ofs), .w_data(wr_data), .w_strb(wr_strb),
    .r_ofs(ar_ofs), .r_hit(cfg_hit), .r_data(cfg_rd), .regs(cfg_q)
  );
  assign cfg_width  = cfg_q[0];
  assign cfg_height = cfg_q[1];
  assign cfg_stride = cfg_q[2];
  assign cfg_format = cfg_q[3];
  assign cfg_plane0 = cfg_q[4];
  assign cfg_plane1 = cfg_q[5];
  assign cfg_field  = cfg_q[6];

  // read data mux and response register
  logic [DATA_W-1:0] rd_val, rdata_q;
  always_comb begin
    case (ar_ofs)
      OFS_CTRL: rd_val = ctrl_word;
      OFS_GIE:  rd_val = DATA_W'(gie_q);
      OFS_IEN:  rd_val = DATA_W'(ien_q);
      OFS_IST:  rd_val = DATA_W'(ist_q);
      default:  rd_val = cfg_hit ? cfg_rd : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ar_hs) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_val;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = 2'b00;
endmodule

// File: rtl/accel_ctrl_regs_chk.sv
module accel_ctrl_regs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_start,
  input logic              core_ready,
  input logic              core_done,
  input logic              wr_commit,
  input logic              done_bit,
  input logic              auto_bit,
  input logic              ar_hs,
  input logic [7:0]        ar_ofs,
  input logic [1:0]        ist_q,
  input logic              bvalid,
  input logic              bready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata
);
  // R1: a pending write response is held until taken
  p_bresp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);

  // R2: accepted start drops when nothing re-arms it
  p_start_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start && core_ready && !core_done && !wr_commit |=> !core_start);

  // R3: done survives until a control read
  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_bit && !(ar_hs && ar_ofs == 8'h00) |=> done_bit);

  // R3: control read with no completion clears done
  p_done_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs && ar_ofs == 8'h00 && !core_done |=> !done_bit);

  // R4: completion under auto-restart re-arms start
  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    auto_bit && core_done |=> core_start);

  // R8: a completion edge always leaves status bit 0 set
  p_ist_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_done) |=> ist_q[0]);

  // R12: read response is stable under back-pressure
  p_rhold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

bind accel_ctrl_regs accel_ctrl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_start(core_start), .core_ready(core_ready), .core_done(core_done),
  .wr_commit(wr_commit), .done_bit(done_bit), .auto_bit(auto_bit),
  .ar_hs(ar_hs), .ar_ofs(ar_ofs), .ist_q(ist_q),
  .bvalid(bvalid), .bready(bready),
  .rvalid(rvalid), .rready(rready), .rdata(rdata)
);

// File: tb/tb_accel_ctrl_regs.sv
module tb_accel_ctrl_regs;
  logic clk = 1'b0;
  always #10 clk = !clk;

  logic        rst_n = 1'b0;
  logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        core_start, flush_req, irq;
  logic        core_done = 0, core_ready = 0, core_idle = 1, flush_done = 0;
  logic [31:0] cfg_o [0:6];

  accel_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .core_start(core_start), .core_done(core_done), .core_ready(core_ready),
    .core_idle(core_idle), .flush_req(flush_req), .flush_done(flush_done),
    .irq(irq),
    .cfg_width(cfg_o[0]), .cfg_height(cfg_o[1]), .cfg_stride(cfg_o[2]),
    .cfg_format(cfg_o[3]), .cfg_plane0(cfg_o[4]), .cfg_plane1(cfg_o[5]),
    .cfg_field(cfg_o[6])
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_done_pulses = 0;
  bit cmp_on = 0, stub_on = 0;
  int stub_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_awh, m_wh, m_bv, m_rv;
  logic [7:0]  m_ao;
  logic [31:0] m_wd, m_rd;
  logic [3:0]  m_ws;
  bit          m_start, m_done, m_flush, m_auto, m_gie;
  logic [1:0]  m_ien, m_ist, m_evq;
  logic [31:0] m_cfg [0:6];

  function automatic int cfg_index(input logic [7:0] o);
    case (o)
      8'h10: return 0; 8'h18: return 1; 8'h20: return 2; 8'h28: return 3;
      8'h30: return 4; 8'h3C: return 5; 8'h48: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] o);
    int k;
    k = cfg_index(o);
    if (o == 8'h00) return {24'h0, m_auto, flush_done, m_flush, 1'b0, core_ready, core_idle, m_done, m_start};
    if (o == 8'h04) return {31'h0, m_gie};
    if (o == 8'h08) return {30'h0, m_ien};
    if (o == 8'h0C) return {30'h0, m_ist};
    if (k >= 0) return m_cfg[k];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_awh = 0; m_wh = 0; m_bv = 0; m_rv = 0; m_ao = 0; m_wd = 0; m_ws = 0; m_rd = 0;
      m_start = 0; m_done = 0; m_flush = 0; m_auto = 0; m_gie = 0;
      m_ien = 0; m_ist = 0; m_evq = 0;
      for (int i = 0; i < 7; i++) m_cfg[i] = 0;
    end else begin : step
      bit c, arh, awa, wa, ns, nd;
      logic [1:0] rise, nist;
      logic [31:0] rv;
      int k;
      c    = m_awh && m_wh && !m_bv;
      arh  = arvalid && !m_rv;
      awa  = awvalid && !m_awh;
      wa   = wvalid && !m_wh;
      rise = {core_ready, core_done} & ~m_evq;
      rv   = model_read(araddr & 8'hFC);
      ns = m_start;
      if (m_start && core_ready) ns = 0;
      if (m_auto && core_done) ns = 1;
      if (c && m_ao == 8'h00 && m_ws[0] && m_wd[0]) ns = 1;
      nd = m_done;
      if (arh && (araddr & 8'hFC) == 8'h00) nd = 0;
      if (core_done) nd = 1;
      nist = m_ist;
      if (c && m_ao == 8'h0C && m_ws[0]) nist = nist ^ m_wd[1:0];
      nist = nist | rise;
      if (c) begin
        if (m_ao == 8'h00 && m_ws[0]) begin m_flush = m_wd[5]; m_auto = m_wd[7]; end
        if (m_ao == 8'h04 && m_ws[0]) m_gie = m_wd[0];
        if (m_ao == 8'h08 && m_ws[0]) m_ien = m_wd[1:0];
        k = cfg_index(m_ao);
        if (k >= 0)
          for (int b = 0; b < 4; b++) if (m_ws[b]) m_cfg[k][b*8 +: 8] = m_wd[b*8 +: 8];
      end
      m_start = ns; m_done = nd; m_ist = nist; m_evq = {core_ready, core_done};
      if (m_bv && bready) m_bv = 0;
      if (c) begin m_awh = 0; m_wh = 0; m_bv = 1; end
      if (awa) begin m_awh = 1; m_ao = awaddr & 8'hFC; end
      if (wa) begin m_wh = 1; m_wd = wdata; m_ws = wstrb; end
      if (m_rv && rready) m_rv = 0;
      if (arh) begin m_rv = 1; m_rd = rv; end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(awready == !m_awh, "R1 awready", awready, !m_awh);
      chk(wready == !m_wh, "R1 wready", wready, !m_wh);
      chk(bvalid == m_bv, "R1 bvalid", bvalid, m_bv);
      chk(arready == !m_rv, "R12 arready", arready, !m_rv);
      chk(rvalid == m_rv, "R12 rvalid", rvalid, m_rv);
      if (rvalid) chk(rdata == m_rd, "R12 rdata", rdata, m_rd);
      chk(core_start == m_start, "R2 core_start", core_start, m_start);
      chk(flush_req == m_flush, "R5 flush_req", flush_req, m_flush);
      chk(irq == (m_gie && |(m_ien & m_ist)), "R9 irq", irq, m_gie && |(m_ien & m_ist));
      for (int i = 0; i < 7; i++) chk(cfg_o[i] == m_cfg[i], "R10 cfg", cfg_o[i], m_cfg[i]);
    end
  end

  // behavioural engine stub
  always @(negedge clk) begin
    if (stub_on) begin
      core_ready <= 0;
      core_done  <= 0;
      if (stub_cnt > 0) begin
        stub_cnt <= stub_cnt - 1;
        if (stub_cnt == 1) core_done <= 1;
        core_idle <= (stub_cnt == 1);
      end else if (core_start) begin
        core_ready <= 1;
        core_idle  <= 0;
        stub_cnt   <= 4;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (core_done) n_done_pulses++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int adly, input int wdly);
    bit ad = 0, wd = 0, ag = 0, wg = 0;
    int c = 0;
    while (!(ad && wd)) begin
      @(negedge clk);
      if (ag) begin awvalid = 0; ad = 1; ag = 0; end
      if (wg) begin wvalid = 0; wd = 1; wg = 0; end
      if (!ad && c >= adly) begin awvalid = 1; awaddr = a; end
      if (!wd && c >= wdly) begin wvalid = 1; wdata = d; wstrb = s; end
      if (awvalid && awready) ag = 1;
      if (wvalid && wready) wg = 1;
      c++;
    end
    while (!bvalid) @(negedge clk);
    chk(bresp == 2'b00, "R11 bresp", bresp, 0);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    arvalid = 1; araddr = a;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    chk(rdata == exp, tag, rdata, exp);
    chk(rresp == 2'b00, "R11 rresp", rresp, 0);
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk(core_start == 0, "R2 reset start", core_start, 0);
    chk(irq == 0, "R9 reset irq", irq, 0);
    chk(bvalid == 0 && rvalid == 0, "R1 reset responses", {bvalid, rvalid}, 0);
    rd(8'h00, 32'h04, "R5 reset control word");

    // R10 / R1: configuration in different channel orders
    wr(8'h10, 32'h0000_0780, 4'hF, 0, 0);
    wr(8'h18, 32'h0000_0438, 4'hF, 4, 0);
    wr(8'h20, 32'h0000_1E00, 4'hF, 0, 3);
    wr(8'h28, 32'hAABB_CCDD, 4'hF, 0, 0);
    wr(8'h28, 32'h1122_3344, 4'b0101, 1, 2);
    wr(8'h30, 32'h8000_0000, 4'hF, 0, 0);
    wr(8'h3C, 32'h8100_0000, 4'hF, 0, 0);
    wr(8'h48, 32'h0000_0001, 4'hF, 0, 0);
    rd(8'h10, 32'h0000_0780, "R10 width");
    rd(8'h18, 32'h0000_0438, "R1 height written W first");
    rd(8'h20, 32'h0000_1E00, "R1 stride written AW first");
    rd(8'h28, 32'hAA22_CC44, "R10 byte strobes");
    rd(8'h3C, 32'h8100_0000, "R10 plane1");

    // R11: unmapped offsets
    wr(8'h14, 32'hDEAD_BEEF, 4'hF, 0, 0);
    rd(8'h14, 32'h0, "R11 unmapped 0x14");
    rd(8'h4C, 32'h0, "R11 unmapped 0x4C");

    // R6: read-only and reserved control bits
    wr(8'h00, 32'hFFFF_FF5E, 4'hF, 0, 0);
    rd(8'h00, 32'h04, "R6 reserved control bits");
    // R5: flush request and live flush-done
    wr(8'h00, 32'h20, 4'h1, 0, 0);
    chk(flush_req == 1, "R5 flush_req", flush_req, 1);
    @(negedge clk); flush_done = 1;
    rd(8'h00, 32'h64, "R5 flush_done live");
    flush_done = 0;
    wr(8'h00, 32'h00, 4'h1, 0, 0);

    // R2: start handshake
    wr(8'h00, 32'h01, 4'h2, 0, 0);
    chk(core_start == 0, "R7 strobe0 required", core_start, 0);
    wr(8'h00, 32'h01, 4'h1, 0, 0);
    repeat (3) @(negedge clk);
    chk(core_start == 1, "R2 start held", core_start, 1);
    wr(8'h00, 32'h00, 4'h1, 0, 0);
    chk(core_start == 1, "R2 write 0 ignored", core_start, 1);
    rd(8'h00, 32'h05, "R2 start readback");
    @(negedge clk); core_ready = 1;
    @(negedge clk); core_ready = 0;
    chk(core_start == 0, "R2 start cleared by handshake", core_start, 0);

    // R3: done and clear-on-read
    pulse_done();
    rd(8'h00, 32'h06, "R3 done set");
    rd(8'h00, 32'h04, "R3 done cleared by read");
    // R3: collision of completion and control read
    @(negedge clk); arvalid = 1; araddr = 8'h00; core_done = 1;
    @(negedge clk); arvalid = 0; core_done = 0;
    while (!rvalid) @(negedge clk);
    chk(rdata == 32'h04, "R3 collision read returns old", rdata, 32'h04);
    @(negedge clk);
    rd(8'h00, 32'h06, "R3 set wins collision");
    rd(8'h00, 32'h04, "R3 cleared afterwards");

    // R7 / R8 / R9: interrupts
    rd(8'h0C, 32'h03, "R8 edges latched");
    chk(irq == 0, "R9 no enable", irq, 0);
    wr(8'h04, 32'hFFFF_FFFF, 4'hF, 0, 0);
    rd(8'h04, 32'h01, "R7 global enable");
    wr(8'h08, 32'hFFFF_FFFF, 4'hF, 0, 0);
    rd(8'h08, 32'h03, "R7 source enables");
    chk(irq == 1, "R9 irq asserted", irq, 1);
    wr(8'h0C, 32'h03, 4'h1, 0, 0);
    rd(8'h0C, 32'h00, "R8 toggle clears");
    chk(irq == 0, "R9 irq cleared", irq, 0);
    wr(8'h0C, 32'h01, 4'h1, 0, 0);
    rd(8'h0C, 32'h01, "R8 toggle sets");
    wr(8'h0C, 32'h01, 4'h1, 0, 0);
    wr(8'h04, 32'h0, 4'h1, 0, 0);
    pulse_done();
    chk(irq == 0, "R9 global gate", irq, 0);
    wr(8'h04, 32'h1, 4'h1, 0, 0);
    chk(irq == 1, "R9 global reenable", irq, 1);
    wr(8'h08, 32'h2, 4'h1, 0, 0);
    chk(irq == 0, "R9 source mask", irq, 0);
    // R8: flip and edge land on the same edge
    @(negedge clk); awvalid = 1; awaddr = 8'h0C; wvalid = 1; wdata = 32'h1; wstrb = 4'hF;
    @(negedge clk); awvalid = 0; wvalid = 0; core_done = 1;
    @(negedge clk); core_done = 0;
    while (!bvalid) @(negedge clk);
    @(negedge clk);
    rd(8'h0C, 32'h01, "R8 edge wins over flip");
    rd(8'h00, 32'h06, "R3 done from pulses");

    // R4: auto-restart with the engine stub
    stub_on = 1;
    n_done_pulses = 0;
    wr(8'h00, 32'h81, 4'h1, 0, 0);
    repeat (60) @(negedge clk);
    chk(n_done_pulses >= 5, "R4 back-to-back runs", n_done_pulses, 5);
    wr(8'h00, 32'h00, 4'h1, 0, 0);
    repeat (20) @(negedge clk);
    chk(core_start == 0, "R4 stops after auto cleared", core_start, 0);
    stub_on = 0;
    @(negedge clk); core_ready = 0; core_done = 0; core_idle = 1; stub_cnt = 0;
    rd(8'h00, 32'h06, "R3 done after runs");

    // R12: read back-pressure
    @(negedge clk); rready = 0; arvalid = 1; araddr = 8'h10;
    @(negedge clk); arvalid = 0;
    repeat (4) begin
      @(negedge clk);
      chk(rvalid == 1 && arready == 0, "R12 held under back-pressure", {rvalid, arready}, 2'b10);
      chk(rdata == 32'h0000_0780, "R12 rdata stable", rdata, 32'h0000_0780);
    end
    rready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(rvalid == 0, "R12 released", rvalid, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule